// File: doc/BRIEF.md
# Vectored Interrupt and Exception Controller

This block sits beside a processor core and decides, once per clock, which pending event the core should take next. It watches a reset request, a nonmaskable interrupt input, an illegal-opcode strobe and a software trap strobe with a 5-bit vector from the core. It also watches 24 maskable interrupt sources. Each maskable source has its own small control register. The register holds a pending flag, a mask bit and a 3-bit programmable level.

Maskable sources are chosen in two steps. The lowest programmed level number wins first. Among sources with the same level, the lowest source index wins. Above the maskable sources stands a fixed ranking: reset request, then the nonmaskable interrupt, then the illegal-opcode exception, then the trap. The winner is turned into an exception code and a 32-bit handler address. The block also outputs a selector that says which program counter the core should save. A separate flag says whether the return address goes into the save register kept for the nonmaskable interrupt or into the ordinary one. All of these outputs are registered and appear together with a one-cycle accept pulse.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset, `take_o` is 0, `code_o` and `handler_o` are 0, and no source is pending. Every source starts masked (`mask`=1) at level 7.
- R2: Accepting maskable source n gives `code_o` = 0x0080 + 16·n and `handler_o` = `code_o` zero-extended to 32 bits. Source 0 gives 0x0080 and source 23 gives 0x01F0.
- R3: If several eligible sources share the same programmed level, the lowest source index is accepted first. The others follow in later cycles.
- R4: A smaller level number takes precedence over a smaller index. Level 0 is the most urgent and level 7 the least.
- R5: A masked source (`cfg_mask_i`=1 written for its index) is never accepted, but its pending flag is kept. Clearing the mask later lets that source be accepted without a new request pulse.
- R6: A maskable source is accepted only while `ie_i`=1. It must also satisfy one of two conditions: `svc_active_i`=0, or its level is numerically smaller than `svc_lvl_i`.
- R7: A one-cycle pulse on `irq_pulse_i[n]` sets the pending flag of source n. Accepting that source clears the flag, so one pulse produces exactly one accept.
- R8: A reset request has the highest rank. It produces `code_o`=0x0000, `handler_o`=0, `pcsel_o`=2 (undefined) and `nmi_save_o`=0.
- R9: The nonmaskable interrupt ignores `ie_i` and outranks all exceptions and maskable sources. It produces `code_o`=0x0010, `handler_o`=0x10, `pcsel_o`=0 and `nmi_save_o`=1. Every other event gives `nmi_save_o`=0.
- R10: A trap with vector v gives `code_o`=0x0040+v. The handler address is 0x40 for v in 0..15 and 0x50 for v in 16..31.
- R11: An illegal opcode gives `code_o`=0x0060, `handler_o`=0x60 and `pcsel_o`=0. It outranks a trap in the same cycle.
- R12: `pcsel_o` encoding: 0 = next PC, 1 = PC of the current instruction, 2 = undefined. A maskable accept while `div_busy_i`=1 gives 1. Traps, illegal opcodes and the nonmaskable interrupt always give 0.
- R13: At most one event is accepted per clock. The outputs appear one cycle after the deciding inputs, and they read 0 while `take_o`=0. A strobe that loses in its cycle is dropped. A maskable source that loses stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request event |
| nmi_i | input | 1 | Nonmaskable interrupt strobe |
| ilgop_i | input | 1 | Illegal-opcode exception strobe |
| trap_i | input | 1 | Software trap strobe |
| trap_vec_i | input | 5 | Trap vector |
| irq_pulse_i | input | 24 | Per-source request pulses |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_idx_i | input | 5 | Source index to write |
| cfg_mask_i | input | 1 | Mask bit to write (1 = masked) |
| cfg_lvl_i | input | 3 | Level to write (0 = most urgent) |
| ie_i | input | 1 | Global maskable interrupt enable |
| svc_active_i | input | 1 | A maskable handler is in service |
| svc_lvl_i | input | 3 | Level of the handler in service |
| div_busy_i | input | 1 | Halfword divide executing |
| take_o | output | 1 | Accept pulse |
| code_o | output | 16 | Exception code |
| handler_o | output | 32 | Handler address |
| pcsel_o | output | 2 | Which PC to save (0 next, 1 current, 2 undefined) |
| nmi_save_o | output | 1 | Save into the NMI return register |

## Verification
Two kinds of collision can happen in the same cycle. The first is between the fixed-rank events and the maskable arbiter: a nonmaskable interrupt can arrive in the very cycle a freshly pending maskable source becomes eligible. The second is between the two synchronous strobes, illegal opcode and trap. The bench sets up both collisions on purpose. It expects the higher-ranked event first. After that it expects the maskable source on the following cycle, with its flag still held. It expects the losing trap to produce nothing at all.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CODE_W = 16;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        PCS_NEXT = 2'd0,
        PCS_CUR  = 2'd1,
        PCS_NONE = 2'd2
    } pc_sel_e;

    localparam logic [CODE_W-1:0] CODE_RESET = 16'h0000;
    localparam logic [CODE_W-1:0] CODE_NMI   = 16'h0010;
    localparam logic [CODE_W-1:0] CODE_TRAP  = 16'h0040;
    localparam logic [CODE_W-1:0] CODE_ILLOP = 16'h0060;
    localparam logic [CODE_W-1:0] CODE_MASK  = 16'h0080;

    typedef struct packed {
        logic              take;
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] handler;
        pc_sel_e           pcsel;
        logic              nmi_save;
    } vec_out_t;

    function automatic logic [CODE_W-1:0] mask_code(input logic [7:0] idx);
        return CODE_MASK + {4'h0, idx, 4'h0};
    endfunction

    function automatic logic [CODE_W-1:0] trap_code(input logic [4:0] v);
        return CODE_TRAP + {11'h000, v};
    endfunction

    function automatic logic [ADDR_W-1:0] trap_handler(input logic [4:0] v);
        return v[4] ? 32'h0000_0050 : 32'h0000_0040;
    endfunction

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
    parameter int NUM_SRC = 24,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             pulse_i,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic                           mask_i,
    input  logic [LVL_W-1:0]               lvl_i,
    input  logic                           ack_i,
    input  logic [IDX_W-1:0]               ack_idx_i,
    output logic [NUM_SRC-1:0]             pend_o,
    output logic [NUM_SRC-1:0]             masked_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic             pend_r;
        logic             mask_r;
        logic [LVL_W-1:0] lvl_r;
        logic             sel_wr;
        logic             sel_ack;

        assign sel_wr  = we_i  && (idx_i     == IDX_W'(i));
        assign sel_ack = ack_i && (ack_idx_i == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_r <= 1'b0;
                mask_r <= 1'b1;
                lvl_r  <= '1;
            end else begin
                if (sel_wr) begin
                    mask_r <= mask_i;
                    lvl_r  <= lvl_i;
                end
                // a new request in the accept cycle keeps the flag set
                if (pulse_i[i])
                    pend_r <= 1'b1;
                else if (sel_ack)
                    pend_r <= 1'b0;
            end
        end

        assign pend_o[i]   = pend_r;
        assign masked_o[i] = mask_r;
        assign lvl_o[i]    = lvl_r;
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 24,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             masked_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_i,
    input  logic                           ie_i,
    input  logic                           svc_active_i,
    input  logic [LVL_W-1:0]               svc_lvl_i,
    output logic                           win_vld_o,
    output logic [IDX_W-1:0]               win_idx_o
);

    logic [NUM_SRC-1:0] elig;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = pend_i[i] && !masked_i[i] && ie_i &&
                         (!svc_active_i || (lvl_i[i] < svc_lvl_i));
    end

    // level first; ties keep the earlier (lower) index via strict compare
    always_comb begin
        logic             found;
        logic [IDX_W-1:0] best_idx;
        logic [LVL_W-1:0] best_lvl;
        found    = 1'b0;
        best_idx = '0;
        best_lvl = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found || (lvl_i[i] < best_lvl))) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_lvl = lvl_i[i];
            end
        end
        win_vld_o = found;
        win_idx_o = best_idx;
    end

endmodule

// File: rtl/irqc_vector_enc.sv
module irqc_vector_enc
    import irqc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             rst_req_i,
    input  logic             nmi_i,
    input  logic             ilgop_i,
    input  logic             trap_i,
    input  logic [4:0]       trap_vec_i,
    input  logic             mask_vld_i,
    input  logic [IDX_W-1:0] mask_idx_i,
    input  logic             div_busy_i,
    output vec_out_t         nxt_o,
    output logic             mask_ack_o
);

    always_comb begin
        nxt_o      = '0;
        mask_ack_o = 1'b0;
        if (rst_req_i) begin
            nxt_o.take    = 1'b1;
            nxt_o.code    = CODE_RESET;
            nxt_o.handler = '0;
            nxt_o.pcsel   = PCS_NONE;
        end else if (nmi_i) begin
            nxt_o.take     = 1'b1;
            nxt_o.code     = CODE_NMI;
            nxt_o.handler  = {16'h0000, CODE_NMI};
            nxt_o.pcsel    = PCS_NEXT;
            nxt_o.nmi_save = 1'b1;
        end else if (ilgop_i) begin
            nxt_o.take    = 1'b1;
            nxt_o.code    = CODE_ILLOP;
            nxt_o.handler = {16'h0000, CODE_ILLOP};
            nxt_o.pcsel   = PCS_NEXT;
        end else if (trap_i) begin
            nxt_o.take    = 1'b1;
            nxt_o.code    = trap_code(trap_vec_i);
            nxt_o.handler = trap_handler(trap_vec_i);
            nxt_o.pcsel   = PCS_NEXT;
        end else if (mask_vld_i) begin
            nxt_o.take    = 1'b1;
            nxt_o.code    = mask_code(8'(mask_idx_i));
            nxt_o.handler = {16'h0000, mask_code(8'(mask_idx_i))};
            nxt_o.pcsel   = div_busy_i ? PCS_CUR : PCS_NEXT;
            mask_ack_o    = 1'b1;
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_req_i,
    input  logic               nmi_i,
    input  logic               ilgop_i,
    input  logic               trap_i,
    input  logic [4:0]         trap_vec_i,
    input  logic [NUM_SRC-1:0] irq_pulse_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic               cfg_mask_i,
    input  logic [LVL_W-1:0]   cfg_lvl_i,
    input  logic               ie_i,
    input  logic               svc_active_i,
    input  logic [LVL_W-1:0]   svc_lvl_i,
    input  logic               div_busy_i,
    output logic               take_o,
    output logic [15:0]        code_o,
    output logic [31:0]        handler_o,
    output logic [1:0]         pcsel_o,
    output logic               nmi_save_o
);

    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            masked;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic                          win_vld;
    logic [IDX_W-1:0]              win_idx;
    logic                          mask_ack;
    vec_out_t                      nxt;
    vec_out_t                      out_q;

    irqc_src_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .pulse_i   (irq_pulse_i),
        .we_i      (cfg_we_i),
        .idx_i     (cfg_idx_i),
        .mask_i    (cfg_mask_i),
        .lvl_i     (cfg_lvl_i),
        .ack_i     (mask_ack),
        .ack_idx_i (win_idx),
        .pend_o    (pend),
        .masked_o  (masked),
        .lvl_o     (lvl)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .pend_i       (pend),
        .masked_i     (masked),
        .lvl_i        (lvl),
        .ie_i         (ie_i),
        .svc_active_i (svc_active_i),
        .svc_lvl_i    (svc_lvl_i),
        .win_vld_o    (win_vld),
        .win_idx_o    (win_idx)
    );

    irqc_vector_enc #(.IDX_W(IDX_W)) u_enc (
        .rst_req_i  (rst_req_i),
        .nmi_i      (nmi_i),
        .ilgop_i    (ilgop_i),
        .trap_i     (trap_i),
        .trap_vec_i (trap_vec_i),
        .mask_vld_i (win_vld),
        .mask_idx_i (win_idx),
        .div_busy_i (div_busy_i),
        .nxt_o      (nxt),
        .mask_ack_o (mask_ack)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign take_o     = out_q.take;
    assign code_o     = out_q.code;
    assign handler_o  = out_q.handler;
    assign pcsel_o    = out_q.pcsel;
    assign nmi_save_o = out_q.nmi_save;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        rst_req_i,
    input logic        nmi_i,
    input logic        ilgop_i,
    input logic        trap_i,
    input logic        ie_i,
    input logic        div_busy_i,
    input logic        take_o,
    input logic [15:0] code_o,
    input logic [31:0] handler_o,
    input logic [1:0]  pcsel_o,
    input logic        nmi_save_o
);

    localparam logic [15:0] TOP_CODE = 16'(16'h0080 + 16 * (NUM_SRC - 1));

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (code_o == 16'h0 && handler_o == 32'h0 && !nmi_save_o)); // R13
    AST_MASK_HANDLER: assert property (@(posedge clk) disable iff (rst)
        (take_o && code_o >= 16'h0080) |-> (handler_o == {16'h0, code_o})); // R2
    AST_MASK_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (take_o && code_o >= 16'h0080) |-> (code_o[3:0] == 4'h0 && code_o <= TOP_CODE)); // R2
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        rst_req_i |=> (take_o && code_o == 16'h0 && handler_o == 32'h0 && pcsel_o == 2'd2)); // R8
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
        (nmi_i && !rst_req_i) |=> (take_o && code_o == 16'h0010 && nmi_save_o)); // R9
    AST_NMI_SAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (take_o && nmi_save_o) |-> (code_o == 16'h0010)); // R9
    AST_TRAP_HANDLER: assert property (@(posedge clk) disable iff (rst)
        (take_o && code_o[15:5] == 11'h002 && code_o != 16'h0060) |->
        (handler_o == (code_o[4] ? 32'h50 : 32'h40))); // R10
    AST_ILLOP_WINS: assert property (@(posedge clk) disable iff (rst)
        (ilgop_i && !nmi_i && !rst_req_i) |=> (take_o && code_o == 16'h0060)); // R11
    AST_DIV_PC: assert property (@(posedge clk) disable iff (rst)
        (take_o && code_o >= 16'h0080) |-> (pcsel_o == ($past(div_busy_i) ? 2'd1 : 2'd0))); // R12
    AST_IE_GATE: assert property (@(posedge clk) disable iff (rst)
        (!ie_i && !rst_req_i && !nmi_i && !ilgop_i && !trap_i) |=> !take_o); // R6

endmodule

bind vec_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_req_i  (rst_req_i),
    .nmi_i      (nmi_i),
    .ilgop_i    (ilgop_i),
    .trap_i     (trap_i),
    .ie_i       (ie_i),
    .div_busy_i (div_busy_i),
    .take_o     (take_o),
    .code_o     (code_o),
    .handler_o  (handler_o),
    .pcsel_o    (pcsel_o),
    .nmi_save_o (nmi_save_o)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        ilgop_i = 1'b0;
    logic        trap_i = 1'b0;
    logic [4:0]  trap_vec_i = '0;
    logic [23:0] irq_pulse_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [4:0]  cfg_idx_i = '0;
    logic        cfg_mask_i = 1'b0;
    logic [2:0]  cfg_lvl_i = '0;
    logic        ie_i = 1'b0;
    logic        svc_active_i = 1'b0;
    logic [2:0]  svc_lvl_i = '0;
    logic        div_busy_i = 1'b0;
    logic        take_o;
    logic [15:0] code_o;
    logic [31:0] handler_o;
    logic [1:0]  pcsel_o;
    logic        nmi_save_o;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [15:0] code;
        logic [31:0] handler;
        logic [1:0]  pcsel;
        logic        nmi;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    vec_irq_ctrl u0 (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_i(nmi_i),
        .ilgop_i(ilgop_i), .trap_i(trap_i), .trap_vec_i(trap_vec_i),
        .irq_pulse_i(irq_pulse_i), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
        .cfg_mask_i(cfg_mask_i), .cfg_lvl_i(cfg_lvl_i), .ie_i(ie_i),
        .svc_active_i(svc_active_i), .svc_lvl_i(svc_lvl_i),
        .div_busy_i(div_busy_i), .take_o(take_o), .code_o(code_o),
        .handler_o(handler_o), .pcsel_o(pcsel_o), .nmi_save_o(nmi_save_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] c, input logic [31:0] h,
                        input logic [1:0] p, input logic n, input string tag);
        exp_t e;
        e.code = c; e.handler = h; e.pcsel = p; e.nmi = n;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    function automatic logic [15:0] mcode(input int n);
        return 16'(16'h0080 + 16 * n);
    endfunction

    // monitor: scoreboard pop and compare on every accept
    always @(negedge clk) begin
        if (!rst && take_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R13", "unexpected accept code", 64'(code_o), 64'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({code_o, handler_o, pcsel_o, nmi_save_o} == e, t,
                    "code/handler/pcsel/nmi",
                    64'({code_o, handler_o, pcsel_o, nmi_save_o}), 64'(e));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int idx, input logic m, input logic [2:0] l);
        cfg_we_i = 1'b1; cfg_idx_i = 5'(idx); cfg_mask_i = m; cfg_lvl_i = l;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [23:0] v);
        irq_pulse_i = v;
        @(negedge clk);
        irq_pulse_i = '0;
    endtask

    task automatic trap(input logic [4:0] v);
        trap_i = 1'b1; trap_vec_i = v;
        @(negedge clk);
        trap_i = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        chk(take_o == 1'b0 && code_o == 16'h0 && handler_o == 32'h0, "R1",
            "reset outputs", 64'({take_o, code_o}), 64'h0);
        // R1/R5: sources start masked, so this request must stay unserved
        ie_i = 1'b1;
        pulse(24'h1 << 3);
        step(3);
        chk(take_o == 1'b0, "R5", "masked source taken", 64'(take_o), 64'h0);

        // R2/R7: single sources at several indices
        cfg(0, 1'b0, 3'd3);
        push(mcode(0), {16'h0, mcode(0)}, 2'd0, 1'b0, "R2");
        pulse(24'h1);
        step(3);
        cfg(7, 1'b0, 3'd5);
        push(mcode(7), {16'h0, mcode(7)}, 2'd0, 1'b0, "R2");
        pulse(24'h1 << 7);
        step(3);
        cfg(23, 1'b0, 3'd5);
        push(mcode(23), {16'h0, mcode(23)}, 2'd0, 1'b0, "R2");
        pulse(24'h1 << 23);
        step(5);
        chk(exp_q.size() == 0 && take_o == 1'b0, "R7", "single accept per pulse",
            64'(exp_q.size()), 64'h0);

        // R3: equal levels, lower index first
        cfg(9, 1'b0, 3'd2);
        cfg(4, 1'b0, 3'd2);
        push(mcode(4), {16'h0, mcode(4)}, 2'd0, 1'b0, "R3");
        push(mcode(9), {16'h0, mcode(9)}, 2'd0, 1'b0, "R3");
        pulse((24'h1 << 9) | (24'h1 << 4));
        step(4);

        // R4: smaller level number beats smaller index
        cfg(2, 1'b0, 3'd6);
        cfg(20, 1'b0, 3'd1);
        push(mcode(20), {16'h0, mcode(20)}, 2'd0, 1'b0, "R4");
        push(mcode(2), {16'h0, mcode(2)}, 2'd0, 1'b0, "R4");
        pulse((24'h1 << 2) | (24'h1 << 20));
        step(4);

        // R5: unmasking the request held since reset
        push(mcode(3), {16'h0, mcode(3)}, 2'd0, 1'b0, "R5");
        cfg(3, 1'b0, 3'd7);
        step(3);

        // R6: global enable and in-service level gate
        ie_i = 1'b0;
        cfg(10, 1'b0, 3'd4);
        pulse(24'h1 << 10);
        step(4);
        chk(take_o == 1'b0, "R6", "taken with ie low", 64'(take_o), 64'h0);
        svc_active_i = 1'b1; svc_lvl_i = 3'd4; ie_i = 1'b1;
        step(4);
        chk(take_o == 1'b0, "R6", "taken at equal level", 64'(take_o), 64'h0);
        push(mcode(10), {16'h0, mcode(10)}, 2'd0, 1'b0, "R6");
        svc_lvl_i = 3'd5;
        step(3);
        svc_active_i = 1'b0;

        // R12: divide in progress
        div_busy_i = 1'b1;
        push(mcode(0), {16'h0, mcode(0)}, 2'd1, 1'b0, "R12");
        pulse(24'h1);
        step(3);
        push(16'h0045, 32'h40, 2'd0, 1'b0, "R12");
        trap(5'd5);
        step(2);
        div_busy_i = 1'b0;

        // R10: trap vectors, back to back
        push(16'h0055, 32'h50, 2'd0, 1'b0, "R10");
        push(16'h005F, 32'h50, 2'd0, 1'b0, "R10");
        push(16'h0050, 32'h50, 2'd0, 1'b0, "R10");
        push(16'h0040, 32'h40, 2'd0, 1'b0, "R10");
        trap(5'd21);
        trap(5'd31);
        trap(5'd16);
        trap(5'd0);
        // R13: last trap visible exactly one cycle after its strobe
        chk(take_o == 1'b1 && code_o == 16'h0040, "R13", "registered latency",
            64'({take_o, code_o}), 64'h1_0040);
        step(2);

        // R11: illegal opcode beats trap in the same cycle
        push(16'h0060, 32'h60, 2'd0, 1'b0, "R11");
        ilgop_i = 1'b1; trap_i = 1'b1; trap_vec_i = 5'd3;
        @(negedge clk);
        ilgop_i = 1'b0; trap_i = 1'b0;
        step(3);
        div_busy_i = 1'b1;
        push(16'h0060, 32'h60, 2'd0, 1'b0, "R12");
        ilgop_i = 1'b1;
        @(negedge clk);
        ilgop_i = 1'b0;
        step(2);
        div_busy_i = 1'b0;

        // R9: nonmaskable ignores ie and beats exceptions
        ie_i = 1'b0;
        push(16'h0010, 32'h10, 2'd0, 1'b1, "R9");
        nmi_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0;
        step(2);
        push(16'h0010, 32'h10, 2'd0, 1'b1, "R9");
        nmi_i = 1'b1; ilgop_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0; ilgop_i = 1'b0;
        step(2);

        // R13: NMI collides with newly pending maskable source
        ie_i = 1'b1;
        cfg(5, 1'b0, 3'd0);
        push(16'h0010, 32'h10, 2'd0, 1'b1, "R13");
        push(mcode(5), {16'h0, mcode(5)}, 2'd0, 1'b0, "R13");
        irq_pulse_i = 24'h1 << 5;
        @(negedge clk);
        irq_pulse_i = '0; nmi_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0;
        step(3);

        // R8: reset request above everything
        push(16'h0000, 32'h0, 2'd2, 1'b0, "R8");
        rst_req_i = 1'b1; nmi_i = 1'b1;
        @(negedge clk);
        rst_req_i = 1'b0; nmi_i = 1'b0;
        step(5);

        chk(exp_q.size() == 0, "R13", "pending expectations", 64'(exp_q.size()), 64'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule